// File: doc/BRIEF.md
# Column Stencil Engine

This block applies a two-tap vertical stencil to a square array of signed 16-bit samples held in on-chip memory. For an array of side n, each result takes the sample one row below in the same column, scaled by one coefficient, and adds the sample one row above, scaled by a second coefficient. The block then shifts the sum right and clamps it to 16 bits. Columns are walked from the first to the last, and rows are walked within each column. Every source sample is fetched exactly once. A two-register window supplies both neighbours, so the walk costs n*n read cycles plus a short fixed drain.

Software loads the source array through a shared host port while the engine is idle. It then pulses `start` with the side length, both coefficients and the shift amount. It waits for the one-cycle `done` pulse and reads the results back through the same port. The results are stored in their own single-port memory at the address of their centre sample.

Top module: `vstencil_engine`

## Requirements
- R1: Element at row i, column j (1 ≤ i,j ≤ n) lives at address (j-1)*n + (i-1) in both arrays. With `host_we` high and the engine idle, a clock edge writes `host_wdata` into the source array. While idle, `host_rdata` presents the result at `host_addr` one cycle after the address is applied.
- R2: Each result for 1 < i < n equals coef_next*b(i+1,j) + coef_prev*b(i-1,j), with all values signed two's complement.
- R3: A neighbour outside the column (row 0 or row n+1) counts as zero. No sample of one column influences another column. For n=1 every result is zero.
- R4: The sum is formed at full precision and shifted right arithmetically by `scale_sh` (0 to 31). It is then clamped to the range -32768..32767 before it is stored.
- R5: Size, coefficients and shift are sampled on the accepted start edge. Later changes to these inputs do not affect the running pass.
- R6: `busy` is high from the cycle after the accepted start edge. `done` pulses high for exactly one cycle, n*n+4 clock edges after the start edge, and `busy` falls on that same edge.
- R7: A start request while `busy` is high is ignored. It alters neither the timing nor the results of the pass in progress.
- R8: A host write while `busy` is high is ignored and does not change the source array.
- R9: A start request with size 0 or a size above NMAX is ignored, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a pass |
| size_n | input | NW (5) | Array side length n |
| coef_next | input | DW (16) | Signed weight on the next-row sample |
| coef_prev | input | DW (16) | Signed weight on the previous-row sample |
| scale_sh | input | SHW (5) | Arithmetic right shift applied to each sum |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle completion pulse |
| host_addr | input | AW (8) | Host address into either array |
| host_we | input | 1 | Host write strobe into the source array |
| host_wdata | input | DW (16) | Host write data |
| host_rdata | output | DW (16) | Result array read data, one cycle latency |

## Verification
The embedded properties watch the handshake on every cycle. They check that `done` lasts a single cycle and that `busy` only falls together with it. They also check that the captured parameters hold still during a pass and that every result write lands inside the current array while the block is busy. The numerical content cannot be checked by these properties. This covers the zeroed edge rows, the column isolation, the shift and clamp behaviour, and the immunity to stray starts and host writes in mid-pass. Only the bench scenarios can show it, by comparing every stored result against a behavioural model for sizes 1, 2, 3, 4, 5 and the maximum.

// File: rtl/vstencil_engine.sv
module vstencil_engine #(
  parameter int DW   = 16,
  parameter int NMAX = 16,
  parameter int SHW  = 5,
  localparam int NW  = $clog2(NMAX + 1),
  localparam int AW  = $clog2(NMAX * NMAX),
  localparam int CNW = AW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NW-1:0]        size_n,
  input  logic signed [DW-1:0] coef_next,
  input  logic signed [DW-1:0] coef_prev,
  input  logic [SHW-1:0]       scale_sh,
  output logic                 busy,
  output logic                 done,
  input  logic [AW-1:0]        host_addr,
  input  logic                 host_we,
  input  logic [DW-1:0]        host_wdata,
  output logic [DW-1:0]        host_rdata
);
  localparam int PW = 2 * DW;
  localparam int SW = 2 * DW + 1;
  localparam int DEPTH = NMAX * NMAX;

  logic signed [DW-1:0] bmem [DEPTH];
  logic        [DW-1:0] amem [DEPTH];

  logic [NW-1:0]        nq;
  logic [CNW-1:0]       nsq;
  logic signed [DW-1:0] k1q, k2q;
  logic [SHW-1:0]       shq;

  logic           iss;
  logic [CNW-1:0] raddr;
  logic [NW-1:0]  row;

  logic                 v1, last1;
  logic [NW-1:0]        r1;
  logic [CNW-1:0]       a1;
  logic signed [DW-1:0] bq;

  logic signed [DW-1:0] d1, d2;
  logic                 pend_end, pend_fin;
  logic [CNW-1:0]       eaddr;

  logic                 v2, l2;
  logic [CNW-1:0]       wa2;
  logic signed [PW-1:0] p1, p2;

  logic                 v3, l3;
  logic [CNW-1:0]       wa3;
  logic signed [SW-1:0] sum3;

  wire start_ok = start && !busy && size_n != '0 && size_n <= NW'(NMAX);
  wire last_row = (row == nq - NW'(1));

  // control: capture, issue counters, completion
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      iss   <= 1'b0;
      raddr <= '0;
      row   <= '0;
      nq    <= '0;
      nsq   <= '0;
      k1q   <= '0;
      k2q   <= '0;
      shq   <= '0;
    end else begin
      done <= v3 && l3;
      if (start_ok) begin
        busy  <= 1'b1;
        iss   <= 1'b1;
        raddr <= '0;
        row   <= '0;
        nq    <= size_n;
        nsq   <= CNW'(size_n) * CNW'(size_n);
        k1q   <= coef_next;
        k2q   <= coef_prev;
        shq   <= scale_sh;
      end else begin
        if (v3 && l3) busy <= 1'b0;
        if (iss) begin
          raddr <= raddr + CNW'(1);
          row   <= last_row ? '0 : row + NW'(1);
          if (raddr == nsq - CNW'(1)) iss <= 1'b0;
        end
      end
    end
  end

  // source memory: host write when idle, one engine read per cycle
  always_ff @(posedge clk) begin
    if (host_we && !busy) bmem[host_addr] <= host_wdata;
    if (iss) bq <= bmem[raddr[AW-1:0]];
  end

  // stage 1 tags and neighbour window
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1       <= 1'b0;
      last1    <= 1'b0;
      r1       <= '0;
      a1       <= '0;
      d1       <= '0;
      d2       <= '0;
      eaddr    <= '0;
      pend_end <= 1'b0;
      pend_fin <= 1'b0;
    end else begin
      v1    <= iss;
      r1    <= row;
      a1    <= raddr;
      last1 <= iss && (raddr == nsq - CNW'(1));
      if (v1) begin
        d1    <= bq;
        d2    <= (r1 == '0) ? '0 : d1;
        eaddr <= a1;
      end
      pend_end <= v1 && (r1 == nq - NW'(1));
      pend_fin <= v1 && last1;
    end
  end

  // a result is due for the previous sample's row
  wire                 emit = pend_end || (v1 && r1 != '0);
  wire signed [DW-1:0] nxt  = pend_end ? '0 : bq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      l2   <= 1'b0;
      wa2  <= '0;
      p1   <= '0;
      p2   <= '0;
      v3   <= 1'b0;
      l3   <= 1'b0;
      wa3  <= '0;
      sum3 <= '0;
    end else begin
      v2   <= emit;
      l2   <= pend_fin;
      wa2  <= eaddr;
      p1   <= k1q * nxt;
      p2   <= k2q * d2;
      v3   <= v2;
      l3   <= v2 && l2;
      wa3  <= wa2;
      sum3 <= SW'(p1) + SW'(p2);
    end
  end

  logic signed [SW-1:0] shf;
  logic [DW-1:0]        res;
  assign shf = sum3 >>> shq;
  always_comb begin
    if ((&shf[SW-1:DW-1]) || !(|shf[SW-1:DW-1])) res = shf[DW-1:0];
    else if (shf[SW-1])                          res = {1'b1, {(DW-1){1'b0}}};
    else                                         res = {1'b0, {(DW-1){1'b1}}};
  end

  // result memory: engine write while running, host read while idle
  always_ff @(posedge clk) begin
    if (v3) amem[wa3[AW-1:0]] <= res;
    else if (!busy) host_rdata <= amem[host_addr];
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_busy_ends_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r5_params_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(k1q) && $stable(k2q) && $stable(shq) && $stable(nq));
  a_r1_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    v3 |-> busy && (wa3 < nsq));
  a_r7_idle_pipe_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !v1 && !v2 && !v3);
endmodule

// File: tb/test_vstencil_engine.sv
module test_vstencil_engine;
  localparam int NMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [4:0] size_n = '0;
  logic signed [15:0] coef_next = '0, coef_prev = '0;
  logic [4:0] scale_sh = '0;
  logic busy, done;
  logic [7:0] host_addr = '0;
  logic host_we = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;

  always #5 clk = ~clk;

  vstencil_engine i_vstencil_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .size_n(size_n),
    .coef_next(coef_next), .coef_prev(coef_prev), .scale_sh(scale_sh),
    .busy(busy), .done(done), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata));

  int n_tests = 0;
  int n_fail  = 0;
  int bref [NMAX*NMAX];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(input int n, input int i, input int j,
                               input int k1, input int k2, input int sh);
    longint nx, pv, s;
    nx = (i + 1 < n) ? bref[j*n + i + 1] : 0;
    pv = (i > 0)     ? bref[j*n + i - 1] : 0;
    s  = longint'(k1) * nx + longint'(k2) * pv;
    s  = s >>> sh;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic load_b(input int n, input int kind);
    for (int a = 0; a < n*n; a++) begin
      int v;
      case (kind)
        0: v = int'($urandom_range(0, 65535)) - 32768;
        1: v = (a % 2 == 0) ? 32767 : -32768;
        default: v = a * 37 - 200;
      endcase
      bref[a] = v;
      @(negedge clk);
      host_we = 1'b1; host_addr = 8'(a); host_wdata = 16'(v);
    end
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic run_pass(input int n, input int k1, input int k2, input int sh,
                          input bit disturb, input string tag);
    int total;
    total = n*n + 4;
    @(negedge clk);
    start = 1'b1; size_n = 5'(n);
    coef_next = 16'(k1); coef_prev = 16'(k2); scale_sh = 5'(sh);
    @(posedge clk);
    for (int c = 0; c <= total; c++) begin
      if (c > 0) @(posedge clk);
      @(negedge clk);
      if (c == 0) begin
        start = disturb;
        if (disturb) begin
          size_n = 5'd2; coef_next = 16'sd1234; coef_prev = -16'sd999; scale_sh = 5'd3;
          host_we = 1'b1; host_addr = 8'(n*n - 1); host_wdata = 16'd12345;
        end
      end else if (c == 1) begin
        start = 1'b0; host_we = 1'b0;
      end
      chk(busy == (c < total), "R6 busy", busy, c < total);
      chk(done == (c == total), disturb ? "R7 done timing" : "R6 done timing", done, c == total);
    end
    for (int a = 0; a < n*n; a++) begin
      int e, i, j;
      i = a % n; j = a / n;
      e = model(n, i, j, k1, k2, sh);
      @(negedge clk);
      host_addr = 8'(a);
      @(posedge clk);
      @(negedge clk);
      if (disturb && a == n*n - 2)
        chk($signed(host_rdata) == e, "R8 host write ignored", $signed(host_rdata), e);
      else if (i == 0 || i == n - 1)
        chk($signed(host_rdata) == e, "R3 edge row", $signed(host_rdata), e);
      else
        chk($signed(host_rdata) == e, tag, $signed(host_rdata), e);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(busy == 1'b0, "R6 reset busy", busy, 0);
    chk(done == 1'b0, "R6 reset done", done, 0);

    load_b(4, 0);
    run_pass(4, 3, -2, 0, 1'b1, "R5 interior");

    load_b(1, 0);
    run_pass(1, 100, 7, 0, 1'b0, "R3 n1");

    load_b(2, 0);
    run_pass(2, -5, 9, 1, 1'b0, "R3 n2");

    load_b(3, 2);
    run_pass(3, 11, 13, 2, 1'b0, "R1 layout");

    load_b(NMAX, 1);
    run_pass(NMAX, 32767, 32767, 4, 1'b0, "R4 saturate");

    load_b(5, 0);
    run_pass(5, -32768, 321, 31, 1'b0, "R4 shift");

    load_b(4, 2);
    run_pass(4, 7, -3, 0, 1'b0, "R2 interior");

    @(negedge clk);
    start = 1'b1; size_n = 5'd0;
    @(negedge clk);
    start = 1'b1; size_n = 5'd17;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R9 bad size", busy, 0);
    chk(done == 1'b0, "R9 no done", done, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule